// File: doc/BRIEF.md
# Burst Input Block Loader

The loader sits in front of a block transform engine. It takes one block of complex samples at a time, with a 16-bit two's complement real part and a 16-bit imaginary part. A block arrives as an unbroken burst of N samples in natural order, and a one-cycle start pulse marks the first sample. The loader writes each sample into a buffer through a registered write port, using sequential addresses that begin at zero. It signals that a load is under way, and it keeps a busy flag raised until the downstream engine reports that the transform of that block is finished.

The start protocol is strict. After reset or a clear, the loader waits for the first block for as long as it takes. After that, a start is only legal on the single cycle that follows the fall of busy. A start pulse that arrives during a burst is treated as sample data and has no effect. A start that arrives while the engine still holds busy, or after the permitted cycle has passed, is dropped and sets a sticky error flag. A synchronous clear aborts any load, loads the block-size selection, clears the flag and arms the loader again.

Top module: `burst_block_loader`

## Requirements
- R1: An accepted start writes the sample present with it to address 0 on the write port one cycle later. Each following sample k is written to address k one cycle after it is presented. The write data is the real part in bits 31:16 and the imaginary part in bits 15:0.
- R2: `loading` goes high on the cycle after an accepted start and stays high for N-1 cycles. It is low on the cycle after the last sample has been captured.
- R3: A start pulse while `loading` is high does not restart the address sequence and does not set the error flag.
- R4: `busy` rises together with `loading` and stays high after the burst until the transform-done input releases it.
- R5: `xformDone` while busy is high and loading is low makes `busy` low on the next cycle. `xformDone` during a burst is ignored.
- R6: A start is accepted only in the armed state that follows reset or clear (until the first block), or on the one cycle right after `busy` falls.
- R7: A start while busy is high and loading is low, or a start while idle after the permitted cycle has passed, is dropped. Such a start produces no write and sets `protoErr`. `protoErr` stays set until a clear.
- R8: `clr` high aborts the burst. On the next cycle `loading`, `busy`, `wrEn` and `protoErr` are low. The loader is armed again, and the size select is loaded (0 selects 2048 samples, 1 selects 8192).
- R9: After the asynchronous reset, all outputs are low, the loader is armed, and the block size is 2048.
- R10: A block is 2048 samples in the small size and 8192 samples in the large size. This is seen as the number of writes and the length of the `loading` interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear; size select is sampled while high |
| sizeSel | input | 1 | Block size select: 0 = 2048, 1 = 8192 |
| inRe | input | 16 | Sample real part, two's complement |
| inIm | input | 16 | Sample imaginary part, two's complement |
| blockStart | input | 1 | Start pulse with the first sample of a block |
| xformDone | input | 1 | Downstream transform finished |
| loading | output | 1 | Burst capture in progress |
| busy | output | 1 | Block held until the transform is done |
| protoErr | output | 1 | Sticky flag for a dropped start |
| wrEn | output | 1 | Buffer write enable |
| wrAddr | output | 13 | Buffer write address |
| wrData | output | 32 | Buffer write data {real, imaginary} |

## Verification
The hardest case to reach is the single cycle in which busy has just fallen, because only there does a start lead to a new burst. The bench reaches it by raising the done input, then driving the next start on the same falling edge at which it sees busy low. It also reaches the locked state that follows a missed window, by letting one idle cycle pass before it sends a start. A clear is issued part way through a large burst to show that the burst is abandoned and that the new size takes hold.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  typedef struct packed {
    logic clear;
    logic accept;
    logic step;
  } ldrStrobe_t;

  typedef enum logic [2:0] {
    ST_FRESH  = 3'd0,
    ST_WINDOW = 3'd1,
    ST_LOCKED = 3'd2,
    ST_LOAD   = 3'd3,
    ST_WAIT   = 3'd4
  } ldrState_t;

endpackage

// File: rtl/ldr_ctrl.sv
module ldr_ctrl
  import ldr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clr,
  input  logic       blockStart,
  input  logic       xformDone,
  input  logic       lastSample,
  output ldrStrobe_t strobe,
  output logic       loading,
  output logic       busy,
  output logic       protoErr
);

  ldrState_t state, stateNext;
  logic      accept;
  logic      errSet;

  // A start is honoured only while armed after reset/clear or in the one-cycle window
  assign accept = blockStart && !clr &&
                  ((state == ST_FRESH) || (state == ST_WINDOW));
  // A start during the hold phase or after a missed window is a protocol error
  assign errSet = blockStart && !clr &&
                  ((state == ST_WAIT) || (state == ST_LOCKED));

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_FRESH:  if (accept) stateNext = ST_LOAD;
      ST_WINDOW: stateNext = accept ? ST_LOAD : ST_LOCKED;
      ST_LOCKED: stateNext = ST_LOCKED;
      ST_LOAD:   if (lastSample) stateNext = ST_WAIT;
      ST_WAIT:   if (xformDone) stateNext = ST_WINDOW;
      default:   stateNext = ST_FRESH;
    endcase
    if (clr) stateNext = ST_FRESH;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_FRESH;
      protoErr <= 1'b0;
    end else begin
      state <= stateNext;
      if (clr)         protoErr <= 1'b0;
      else if (errSet) protoErr <= 1'b1;
    end
  end

  assign loading = (state == ST_LOAD);
  assign busy    = (state == ST_LOAD) || (state == ST_WAIT);

  assign strobe.clear  = clr;
  assign strobe.accept = accept;
  assign strobe.step   = loading && !clr;

  a_r2_start_raises_loading: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> loading);
  a_r4_busy_covers_loading: assert property (@(posedge clk) disable iff (!rstN)
    loading |-> busy);
  a_r5_done_releases: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !loading && xformDone && !clr) |=> !busy);
  a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (protoErr && !clr) |=> protoErr);
  a_r3_no_error_in_burst: assert property (@(posedge clk) disable iff (!rstN)
    (loading && !protoErr && !clr) |=> !protoErr);
  a_r8_clear_drops_status: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (!loading && !busy && !protoErr));

endmodule

// File: rtl/ldr_datapath.sv
module ldr_datapath
  import ldr_pkg::*;
#(
  parameter int SMALL_LOG2 = 11,
  parameter int LARGE_LOG2 = 13,
  parameter int SAMPLE_W   = 16,
  localparam int ADDR_W    = LARGE_LOG2,
  localparam int WORD_W    = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ldrStrobe_t          strobe,
  input  logic                sizeSel,
  input  logic [SAMPLE_W-1:0] inRe,
  input  logic [SAMPLE_W-1:0] inIm,
  output logic                lastSample,
  output logic                wrEn,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [WORD_W-1:0]   wrData
);

  localparam logic [ADDR_W-1:0] SMALL_LAST = ADDR_W'((1 << SMALL_LOG2) - 1);
  localparam logic [ADDR_W-1:0] LARGE_LAST = {ADDR_W{1'b1}};

  logic              sizeLarge;
  logic [ADDR_W-1:0] cnt;
  logic [ADDR_W-1:0] lastIdx;

  assign lastIdx    = sizeLarge ? LARGE_LAST : SMALL_LAST;
  assign lastSample = (cnt == lastIdx);

  // Size select and sample counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeLarge <= 1'b0;
      cnt       <= '0;
    end else if (strobe.clear) begin
      sizeLarge <= sizeSel;
      cnt       <= '0;
    end else if (strobe.accept) begin
      cnt <= {{(ADDR_W-1){1'b0}}, 1'b1};
    end else if (strobe.step) begin
      cnt <= lastSample ? '0 : cnt + 1'b1;
    end
  end

  // Registered buffer write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else if (strobe.clear) begin
      wrEn   <= 1'b0;
      wrAddr <= '0;
    end else begin
      wrEn   <= strobe.accept || strobe.step;
      wrAddr <= strobe.accept ? '0 : cnt;
      if (strobe.accept || strobe.step) wrData <= {inRe, inIm};
    end
  end

  a_r1_first_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |=> (wrEn && wrAddr == '0));
  a_r1_addr_follows_count: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (wrEn && wrAddr == $past(cnt)));
  a_r8_clear_quiets_port: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (!wrEn && cnt == '0));
  a_r10_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (cnt <= lastIdx));

endmodule

// File: rtl/burst_block_loader.sv
module burst_block_loader
  import ldr_pkg::*;
#(
  parameter int SMALL_LOG2 = 11,
  parameter int LARGE_LOG2 = 13,
  parameter int SAMPLE_W   = 16,
  localparam int ADDR_W    = LARGE_LOG2,
  localparam int WORD_W    = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clr,
  input  logic                sizeSel,
  input  logic [SAMPLE_W-1:0] inRe,
  input  logic [SAMPLE_W-1:0] inIm,
  input  logic                blockStart,
  input  logic                xformDone,
  output logic                loading,
  output logic                busy,
  output logic                protoErr,
  output logic                wrEn,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [WORD_W-1:0]   wrData
);

  ldrStrobe_t strobe;
  logic       lastSample;

  ldr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clr        (clr),
    .blockStart (blockStart),
    .xformDone  (xformDone),
    .lastSample (lastSample),
    .strobe     (strobe),
    .loading    (loading),
    .busy       (busy),
    .protoErr   (protoErr)
  );

  ldr_datapath #(
    .SMALL_LOG2 (SMALL_LOG2),
    .LARGE_LOG2 (LARGE_LOG2),
    .SAMPLE_W   (SAMPLE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sizeSel    (sizeSel),
    .inRe       (inRe),
    .inIm       (inIm),
    .lastSample (lastSample),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData)
  );

endmodule

// File: tb/sim_burst_block_loader.sv
module sim_burst_block_loader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clr = 1'b0;
  logic        sizeSel = 1'b0;
  logic [15:0] inRe = '0;
  logic [15:0] inIm = '0;
  logic        blockStart = 1'b0;
  logic        xformDone = 1'b0;
  logic        loading, busy, protoErr, wrEn;
  logic [12:0] wrAddr;
  logic [31:0] wrData;

  int checks = 0;
  int errors = 0;
  bit expErr = 1'b0;
  bit done = 1'b0;

  int          qAddr[$];
  logic [31:0] qData[$];

  always #5 clk = ~clk;

  burst_block_loader u0 (
    .clk(clk), .rstN(rstN), .clr(clr), .sizeSel(sizeSel),
    .inRe(inRe), .inIm(inIm), .blockStart(blockStart), .xformDone(xformDone),
    .loading(loading), .busy(busy), .protoErr(protoErr),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected write per observed write
  always @(negedge clk) begin
    if (rstN && wrEn) begin
      if (qAddr.size() == 0) begin
        chk(1'b0, "R1 R7 unexpected write", int'(wrAddr), -1);
      end else begin
        int ea;
        logic [31:0] ed;
        ea = qAddr.pop_front();
        ed = qData.pop_front();
        chk(int'(wrAddr) == ea, "R1 address", int'(wrAddr), ea);
        chk(wrData == ed, "R1 data", int'(wrData), int'(ed));
      end
    end
  end

  task automatic drive(input int k, input int seed);
    logic [15:0] re, im;
    re = 16'(k * seed + 3);
    im = ~16'(k ^ seed);
    inRe = re;
    inIm = im;
    qAddr.push_back(k);
    qData.push_back({re, im});
  endtask

  // Called on a falling edge at which a start is legal
  task automatic sendBlock(input int n, input int seed, input int dupAt,
                           input int doneAt, input int clrAt);
    blockStart = 1'b1;
    drive(0, seed);
    for (int k = 1; k < n; k++) begin
      @(negedge clk);
      blockStart = (k == dupAt);   // R3 stray start inside the burst
      xformDone  = (k == doneAt);  // R5 done during the burst
      chk(loading == 1'b1, "R2 loading during burst", int'(loading), 1);
      if (k == clrAt) begin
        clr = 1'b1;
        blockStart = 1'b0;
        xformDone = 1'b0;
        @(negedge clk);
        clr = 1'b0;
        expErr = 1'b0;
        chk(loading == 1'b0, "R8 loading after clear", int'(loading), 0);
        chk(busy == 1'b0, "R8 busy after clear", int'(busy), 0);
        chk(wrEn == 1'b0, "R8 write after clear", int'(wrEn), 0);
        chk(protoErr == 1'b0, "R8 error after clear", int'(protoErr), 0);
        return;
      end
      drive(k, seed);
    end
    @(negedge clk);
    blockStart = 1'b0;
    xformDone = 1'b0;
    chk(loading == 1'b0, "R2 R10 loading ends after N samples", int'(loading), 0);
    chk(busy == 1'b1, "R4 R5 busy held after burst", int'(busy), 1);
    chk(protoErr == expErr, "R3 error unchanged by burst", int'(protoErr), int'(expErr));
  endtask

  task automatic finishXform();
    xformDone = 1'b1;
    @(negedge clk);
    xformDone = 1'b0;
    chk(busy == 1'b0, "R5 busy released", int'(busy), 0);
  endtask

  task automatic strayStart(input string req);
    blockStart = 1'b1;
    @(negedge clk);
    blockStart = 1'b0;
    expErr = 1'b1;
    chk(protoErr == 1'b1, req, int'(protoErr), 1);
    chk(loading == 1'b0, "R6 stray start not accepted", int'(loading), 0);
    @(negedge clk);
  endtask

  task automatic doClear(input bit sz);
    clr = 1'b1;
    sizeSel = sz;
    @(negedge clk);
    clr = 1'b0;
    expErr = 1'b0;
    chk(protoErr == 1'b0, "R8 error cleared", int'(protoErr), 0);
    chk(busy == 1'b0, "R8 busy cleared", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(loading == 1'b0, "R9 loading in reset", int'(loading), 0);
    chk(busy == 1'b0, "R9 busy in reset", int'(busy), 0);
    chk(wrEn == 1'b0, "R9 write in reset", int'(wrEn), 0);
    chk(protoErr == 1'b0, "R9 error in reset", int'(protoErr), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    // R6 armed after reset for any length of time; R9 default small size
    sendBlock(2048, 7, 100, 500, -1);
    repeat (3) @(negedge clk);
    strayStart("R7 start while busy");
    finishXform();
    // R6 start in the window right after busy falls
    sendBlock(2048, 29, -1, -1, -1);
    finishXform();
    @(negedge clk);
    strayStart("R7 start after missed window");
    doClear(1'b1);
    // R8 abort part way through a large burst
    sendBlock(8192, 5, -1, -1, 1000);
    repeat (5) @(negedge clk);
    // R10 full large block
    sendBlock(8192, 11, 4000, -1, -1);
    finishXform();
    doClear(1'b0);
    // R8 size select returns to small
    sendBlock(2048, 3, -1, -1, -1);
    finishXform();
    repeat (3) @(negedge clk);
    chk(qAddr.size() == 0, "R1 all expected writes seen", qAddr.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule